// File: doc/BRIEF.md
# Descriptor-Chained Memory Fill Engine

The block masters a word-wide memory port. It walks a linked list of descriptors held in memory and, for each descriptor, writes one constant 32-bit pattern over a destination buffer. Software reaches it through a small 32-bit register port. Software first loads the byte address of the first descriptor. It then writes the start bit and reads the status register until the activity flag drops. After that it inspects the error flag and clears the sticky flags by writing them back.

A descriptor is eight consecutive 32-bit words. Word 0 is the link to the next descriptor, and a link of zero ends the chain. Word 1 is the fill pattern. Words 2 to 4 are fetched but not used. Word 5 is the destination byte address and word 6 is the byte count. Word 7 is the control word: its bits 3:1 hold a command code, where the value 2 means fill, and its bit 31 enables destination writes. The same master port fetches descriptors and writes fill data. Every transfer is a single word and is held until the memory accepts it.

Top module: `fill_chain_engine`

## Requirements
- R1: A register write to offset 0x00 with bit 0 set, while the engine is idle, starts a chain at the descriptor address held at offset 0x0C. Status bit 10 reads 1 from then until the chain ends.
- R2: Each descriptor is fetched with exactly eight single-word reads at ascending addresses base, base+4, ... base+28. Words 2 to 4 have no effect.
- R3: With command code 2 in control bits 3:1 and control bit 31 set, the engine writes the pattern (word 1) to count/4 consecutive words starting at the destination (word 5), with the address stepping by 4.
- R4: When control bit 31 is clear, a valid descriptor produces no memory write and the chain continues with its link.
- R5: A link (word 0) of zero ends the chain after the current descriptor. Any other link is fetched next, with its bits 1:0 treated as zero.
- R6: A count of zero, a count that is not a multiple of 4, a destination with bits 1:0 nonzero, or a command code other than 2 sets status bit 5. The chain then ends with no write for that descriptor, and status bit 10 clears.
- R7: Status bit 9 is set whenever a chain ends by itself, normally or on an error. It is not set by a stop.
- R8: Status bits 5 and 9 stay set until a status write carries a 1 in that bit position. Writing 0 to a bit leaves it unchanged, and writes do not affect bit 10.
- R9: A write of 0 in bit 0 to offset 0x00 stops the engine. The request drops on the next cycle, status bit 10 reads 0, and no further memory transfer occurs.
- R10: While status bit 10 is set, a start write is ignored and writes to offset 0x0C leave the descriptor address unchanged.
- R11: A memory request keeps its address, direction and data stable until mem_ready is high. Fill writes proceed at one word per cycle while mem_ready stays high.
- R12: After reset the control, status and descriptor-address registers read 0 and no memory request is raised.
- R13: A read returns data on reg_rdata in the cycle after reg_rd. Offset 0x00 returns the last accepted enable bit in bit 0, offset 0x0C returns the address with bits 1:0 as zero, and all other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid while mem_ready is high |
| mem_ready | input | 1 | Memory accepts the current transfer |

## Verification
The assertions assume a memory that returns read data in the same cycle it raises mem_ready. They also assume that nobody writes a start bit in the same cycle as a stop. The bench models such a memory with a zero-wait path and with a repeating stall pattern. It only issues register accesses one at a time, from tasks. Descriptors and fill buffers lie in separate regions of the modelled memory, so a stray write shows up as a mismatch against the expected memory image.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int DW        = 32;
  localparam int BEAT_W    = DW - 2;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W     = $clog2(DESC_WORDS);

  // register byte offsets
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_PTR  = 4'hC;

  // status bit positions
  localparam int ST_ACT  = 10;
  localparam int ST_DONE = 9;
  localparam int ST_ERR  = 5;

  // descriptor word indices
  localparam logic [IDX_W-1:0] W_LINK = 3'd0;
  localparam logic [IDX_W-1:0] W_PAT  = 3'd1;
  localparam logic [IDX_W-1:0] W_DEST = 3'd5;
  localparam logic [IDX_W-1:0] W_CNT  = 3'd6;
  localparam logic [IDX_W-1:0] W_CTL  = 3'd7;

  localparam logic [2:0] CMD_FILL = 3'd2;
  localparam int CTL_WEN = 31;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_EVAL,
    SQ_FILL
  } seq_state_e;
endpackage

// File: rtl/fce_regs.sv
module fce_regs
  import fce_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              end_p,
  input  logic              fault_p,
  output logic              start_p,
  output logic              stop_p,
  output logic [ADDR_W-1:0] first_ptr,
  output logic              err_flag,
  output logic              done_flag
);
  logic hit_ctrl, hit_stat, hit_ptr;
  logic en_q;
  logic [DW-1:0] stat_view;
  logic unused_wdata;

  assign hit_ctrl = (reg_addr == REG_AW'(OFF_CTRL));
  assign hit_stat = (reg_addr == REG_AW'(OFF_STAT));
  assign hit_ptr  = (reg_addr == REG_AW'(OFF_PTR));

  assign start_p = reg_wr & hit_ctrl &  reg_wdata[0] & ~busy;
  assign stop_p  = reg_wr & hit_ctrl & ~reg_wdata[0];

  assign unused_wdata = ^reg_wdata;

  always_comb begin
    stat_view = '0;
    stat_view[ST_ACT]  = busy;
    stat_view[ST_DONE] = done_flag | end_p;
    stat_view[ST_ERR]  = err_flag | fault_p;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      first_ptr <= '0;
      err_flag  <= 1'b0;
      done_flag <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && hit_ctrl && (!busy || !reg_wdata[0]))
        en_q <= reg_wdata[0];
      if (reg_wr && hit_ptr && !busy)
        first_ptr <= {reg_wdata[ADDR_W-1:2], 2'b00};
      if (fault_p)
        err_flag <= 1'b1;
      else if (reg_wr && hit_stat && reg_wdata[ST_ERR])
        err_flag <= 1'b0;
      if (end_p)
        done_flag <= 1'b1;
      else if (reg_wr && hit_stat && reg_wdata[ST_DONE])
        done_flag <= 1'b0;
      if (reg_rd) begin
        if (hit_ctrl)      reg_rdata <= DW'(en_q);
        else if (hit_stat) reg_rdata <= stat_view;
        else if (hit_ptr)  reg_rdata <= DW'(first_ptr);
        else               reg_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/fce_desc_decode.sv
module fce_desc_decode
  import fce_pkg::*;
(
  input  logic [1:0]        dest_lo,
  input  logic [DW-1:0]     cnt,
  input  logic [DW-1:0]     ctl,
  output logic              bad,
  output logic              wen,
  output logic [BEAT_W-1:0] beats
);
  logic cnt_zero, cnt_frac, dest_mis, cmd_bad;
  logic unused_ctl;

  assign cnt_zero = (cnt == '0);
  assign cnt_frac = (cnt[1:0] != 2'b00);
  assign dest_mis = (dest_lo != 2'b00);
  assign cmd_bad  = (ctl[3:1] != CMD_FILL);
  assign bad      = cnt_zero | cnt_frac | dest_mis | cmd_bad;
  assign wen      = ctl[CTL_WEN];
  assign beats    = cnt[DW-1:2];
  assign unused_ctl = ^{ctl[30:4], ctl[0]};
endmodule

// File: rtl/fce_seq.sv
module fce_seq
  import fce_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [ADDR_W-1:0] first_ptr,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              d_bad,
  input  logic              d_wen,
  input  logic [BEAT_W-1:0] d_beats,
  output logic [ADDR_W-1:0] d_dest,
  output logic [DW-1:0]     d_cnt,
  output logic [DW-1:0]     d_ctl,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              busy,
  output logic              end_p,
  output logic              fault_p
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(DESC_WORDS - 1);

  seq_state_e state;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] link;
  logic [DW-1:0]     pat;
  logic [BEAT_W-1:0] left;
  logic              unused_rd;

  assign unused_rd = ^mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      idx       <= '0;
      link      <= '0;
      pat       <= '0;
      left      <= '0;
      d_dest    <= '0;
      d_cnt     <= '0;
      d_ctl     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      end_p     <= 1'b0;
      fault_p   <= 1'b0;
    end else begin
      end_p   <= 1'b0;
      fault_p <= 1'b0;
      if (stop_p) begin
        state   <= SQ_IDLE;
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
        busy    <= 1'b0;
      end else begin
        case (state)
          SQ_IDLE: begin
            if (start_p) begin
              busy     <= 1'b1;
              state    <= SQ_FETCH;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= first_ptr;
              idx      <= '0;
            end
          end
          SQ_FETCH: begin
            if (mem_ready) begin
              case (idx)
                W_LINK: link   <= {mem_rdata[ADDR_W-1:2], 2'b00};
                W_PAT:  pat    <= mem_rdata;
                W_DEST: d_dest <= mem_rdata[ADDR_W-1:0];
                W_CNT:  d_cnt  <= mem_rdata;
                W_CTL:  d_ctl  <= mem_rdata;
                default: ;
              endcase
              if (idx == LAST) begin
                mem_req <= 1'b0;
                state   <= SQ_EVAL;
              end else begin
                idx      <= idx + 1'b1;
                mem_addr <= mem_addr + STEP;
              end
            end
          end
          SQ_EVAL: begin
            if (d_bad) begin
              fault_p <= 1'b1;
              end_p   <= 1'b1;
              busy    <= 1'b0;
              state   <= SQ_IDLE;
            end else if (d_wen) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= d_dest;
              mem_wdata <= pat;
              left      <= d_beats;
              state     <= SQ_FILL;
            end else if (link == '0) begin
              busy  <= 1'b0;
              end_p <= 1'b1;
              state <= SQ_IDLE;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= link;
              idx      <= '0;
              state    <= SQ_FETCH;
            end
          end
          SQ_FILL: begin
            if (mem_ready) begin
              if (left == BEAT_W'(1)) begin
                mem_we <= 1'b0;
                if (link == '0) begin
                  mem_req <= 1'b0;
                  busy    <= 1'b0;
                  end_p   <= 1'b1;
                  state   <= SQ_IDLE;
                end else begin
                  mem_addr <= link;
                  idx      <= '0;
                  state    <= SQ_FETCH;
                end
              end else begin
                left     <= left - 1'b1;
                mem_addr <= mem_addr + STEP;
              end
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fill_chain_engine.sv
module fill_chain_engine
  import fce_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready
);
  logic              busy_w, end_w, fault_w, start_w, stop_w;
  logic              err_w, done_w;
  logic [ADDR_W-1:0] ptr_w, dest_w;
  logic [DW-1:0]     cnt_w, ctl_w;
  logic              bad_w, wen_w;
  logic [BEAT_W-1:0] beats_w;

  fce_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy_w), .end_p(end_w), .fault_p(fault_w),
    .start_p(start_w), .stop_p(stop_w), .first_ptr(ptr_w),
    .err_flag(err_w), .done_flag(done_w)
  );

  fce_desc_decode dec_i (
    .dest_lo(dest_w[1:0]), .cnt(cnt_w), .ctl(ctl_w),
    .bad(bad_w), .wen(wen_w), .beats(beats_w)
  );

  fce_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst(rst), .start_p(start_w), .stop_p(stop_w),
    .first_ptr(ptr_w), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .d_bad(bad_w), .d_wen(wen_w), .d_beats(beats_w),
    .d_dest(dest_w), .d_cnt(cnt_w), .d_ctl(ctl_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy_w), .end_p(end_w), .fault_p(fault_w)
  );
endmodule

// File: rtl/fce_chk.sv
module fce_chk #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              busy,
  input logic [ADDR_W-1:0] ptr,
  input logic              err_flag
);
  logic stop_in, errclr_in;
  assign stop_in   = reg_wr && (reg_addr == REG_AW'(0)) && !reg_wdata[0];
  assign errclr_in = reg_wr && (reg_addr == REG_AW'(4)) && reg_wdata[5];

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready && !stop_in) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stop_in |=> (!mem_req && !busy));

  // R3
  wr_align_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr[1:0] == 2'b00));

  // R1
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R10
  ptr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !errclr_in) |=> err_flag);
endmodule

bind fill_chain_engine fce_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .busy(busy_w), .ptr(ptr_w), .err_flag(err_w)
);

// File: tb/fill_chain_engine_tb.sv
module fill_chain_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 256;
  localparam logic [31:0] ACT  = 32'h400;
  localparam logic [31:0] DONE = 32'h200;
  localparam logic [31:0] ERR  = 32'h020;
  localparam logic [31:0] C_FILL = 32'h8000_0004;
  localparam logic [31:0] C_NOWR = 32'h0000_0004;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem  [MEM_WORDS];
  logic [31:0] expv [MEM_WORDS];
  int total = 0, bad = 0;
  int cyc = 0, wr_beats = 0, rd_beats = 0, first_wr = -1, last_wr = -1;
  int rd_seq_bad = 0;
  logic [31:0] last_rd = '0;
  bit throttle = 1'b0;
  bit finished = 1'b0;

  fill_chain_engine dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  initial mem_ready = 1'b1;
  always @(negedge clk) mem_ready <= throttle ? ((cyc % 3) != 1) : 1'b1;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata;
        wr_beats = wr_beats + 1;
        if (first_wr < 0) first_wr = cyc;
        last_wr = cyc;
      end else begin
        if ((rd_beats % 8) != 0 && mem_addr != last_rd + 32'd4)
          rd_seq_bad = rd_seq_bad + 1;
        last_rd = mem_addr;
        rd_beats = rd_beats + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = ACT;
    for (int i = 0; i < 3000 && st[10]; i++) rd(4'h4, st);
  endtask

  task automatic init_mem();
    for (int i = 0; i < MEM_WORDS; i++) begin
      mem[i]  = 32'h5A5A_0000 | i;
      expv[i] = mem[i];
    end
    wr_beats = 0; rd_beats = 0; first_wr = -1; last_wr = -1; rd_seq_bad = 0;
  endtask

  task automatic put_desc(input int wi, input logic [31:0] lnk, pat, dst, cnt, ctl);
    mem[wi] = lnk; mem[wi+1] = pat;
    mem[wi+2] = 32'hFFFF_FFFF; mem[wi+3] = 32'h1234_5678; mem[wi+4] = 32'hDEAD_BEEF;
    mem[wi+5] = dst; mem[wi+6] = cnt; mem[wi+7] = ctl;
    for (int i = 0; i < 8; i++) expv[wi+i] = mem[wi+i];
  endtask

  task automatic exp_fill(input logic [31:0] dst, input int n, input logic [31:0] pat);
    for (int i = 0; i < n; i++) expv[dst[9:2] + i] = pat;
  endtask

  task automatic cmp_mem(input string req);
    int miss = 0, at = -1;
    for (int i = 0; i < MEM_WORDS; i++)
      if (mem[i] !== expv[i]) begin
        miss++;
        if (at < 0) at = i;
      end
    if (at < 0) at = 0;
    check(miss == 0, req, $sformatf("memory image word %0d", at), mem[at], expv[at]);
  endtask

  task automatic run_from(input logic [31:0] p, output logic [31:0] st);
    wr(4'hC, p);
    wr(4'h0, 32'h1);
    wait_idle(st);
    wr(4'h0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] st, v;
    int w;
    init_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    check(reg_rdata == 0 && mem_req == 1'b0, "R12", "reset outputs", {31'b0, mem_req}, 0);
    rd(4'h0, v); check(v == 0, "R12", "ctrl after reset", v, 0);
    rd(4'h4, v); check(v == 0, "R12", "status after reset", v, 0);
    rd(4'hC, v); check(v == 0, "R12", "pointer after reset", v, 0);

    // R13 readback
    wr(4'hC, 32'h0000_0123); rd(4'hC, v);
    check(v == 32'h120, "R13", "pointer low bits", v, 32'h120);
    rd(4'h8, v); check(v == 0, "R13", "unused offset", v, 0);

    // R3 R2 R11 sweep over length, offset and stall pattern
    for (int n = 1; n <= 12; n++) begin
      for (int off = 0; off < 4; off++) begin
        logic [31:0] pat, dst;
        init_mem();
        throttle = ((n + off) % 2) == 1;
        pat = 32'hA500_0000 ^ (n * 32'h0101) ^ (off << 20);
        dst = 32'h100 + off * 32'h44;
        put_desc(0, 32'h0, pat, dst, n * 4, C_FILL);
        exp_fill(dst, n, pat);
        run_from(32'h0, st);
        check(st == DONE, "R3", "status after fill", st, DONE);
        cmp_mem("R3");
        check(wr_beats == n, "R3", "write beat count", wr_beats, n);
        check(rd_beats == 8 && rd_seq_bad == 0, "R2", "descriptor reads", rd_beats, 8);
        if (!throttle)
          check(last_wr - first_wr + 1 == n, "R11", "back-to-back writes",
                last_wr - first_wr + 1, n);
        wr(4'h4, DONE);
      end
    end
    throttle = 1'b0;

    // R4 R5 chain: no-write descriptor, link with low bits set, two fills
    init_mem();
    put_desc(0,  32'h21, 32'h1111_1111, 32'h100, 16, C_NOWR);
    put_desc(8,  32'h40, 32'h2222_2222, 32'h200, 12, C_FILL);
    put_desc(16, 32'h0,  32'h3333_3333, 32'h300, 20, C_FILL);
    exp_fill(32'h200, 3, 32'h2222_2222);
    exp_fill(32'h300, 5, 32'h3333_3333);
    throttle = 1'b1;
    run_from(32'h0, st);
    throttle = 1'b0;
    check(st == DONE, "R5", "chain status", st, DONE);
    cmp_mem("R4");
    check(wr_beats == 8, "R5", "chain write beats", wr_beats, 8);
    check(rd_beats == 24 && rd_seq_bad == 0, "R5", "three descriptors fetched", rd_beats, 24);
    wr(4'h4, DONE);

    // R6 error cases, each after a good descriptor, bad one links onward
    for (int k = 0; k < 4; k++) begin
      logic [31:0] cnt, dst, ctl;
      init_mem();
      cnt = 32'd16; dst = 32'h200; ctl = C_FILL;
      if (k == 0) cnt = 32'd0;
      if (k == 1) cnt = 32'd6;
      if (k == 2) dst = 32'h202;
      if (k == 3) ctl = 32'h8000_0006;
      put_desc(0,  32'h20, 32'hC0DE_0000 | k, 32'h100, 8, C_FILL);
      put_desc(8,  32'h40, 32'hBAD0_0000 | k, dst, cnt, ctl);
      put_desc(16, 32'h0,  32'hEEEE_EEEE, 32'h300, 8, C_FILL);
      exp_fill(32'h100, 2, 32'hC0DE_0000 | k);
      run_from(32'h0, st);
      check(st == (DONE | ERR), "R6", $sformatf("error case %0d status", k), st, DONE | ERR);
      cmp_mem("R6");
      check(rd_beats == 16, "R6", "chain ends at bad descriptor", rd_beats, 16);
      if (k < 3) wr(4'h4, DONE | ERR);
    end

    // R8 write-one-to-clear
    wr(4'h4, 32'h0); rd(4'h4, v);
    check(v == (DONE | ERR), "R8", "write 0 keeps flags", v, DONE | ERR);
    wr(4'h4, ERR | ACT); rd(4'h4, v);
    check(v == DONE, "R8", "clear error only", v, DONE);
    wr(4'h4, DONE); rd(4'h4, v);
    check(v == 0, "R8", "clear done", v, 0);

    // R9 R7 stop in the middle of a long fill
    init_mem();
    put_desc(0, 32'h0, 32'h7777_0000, 32'h100, 400, C_FILL);
    throttle = 1'b1;
    wr(4'hC, 32'h0); wr(4'h0, 32'h1);
    repeat (40) @(negedge clk);
    wr(4'h0, 32'h0);
    rd(4'h4, st);
    check(st == 0, "R9", "status after stop", st, 0);
    check(st[9] == 1'b0, "R7", "stop sets no done", st, 0);
    w = wr_beats;
    repeat (30) @(negedge clk);
    check(wr_beats == w && w > 0 && w < 100, "R9", "no writes after stop", wr_beats, w);
    check(mem_req == 1'b0, "R9", "request low after stop", mem_req, 0);
    exp_fill(32'h100, w, 32'h7777_0000);
    cmp_mem("R9");
    rd(4'h0, v); check(v == 0, "R13", "ctrl reads enable 0", v, 0);
    throttle = 1'b0;

    // R10 start and pointer writes ignored while active
    init_mem();
    put_desc(0,  32'h0, 32'h4444_0000, 32'h100, 240, C_FILL);
    put_desc(32, 32'h0, 32'h9999_9999, 32'h300, 16, C_FILL);
    exp_fill(32'h100, 60, 32'h4444_0000);
    throttle = 1'b1;
    wr(4'hC, 32'h0); wr(4'h0, 32'h1);
    rd(4'h0, v); check(v == 1, "R13", "ctrl reads enable 1", v, 1);
    repeat (10) @(negedge clk);
    wr(4'hC, 32'h80); wr(4'h0, 32'h1);
    rd(4'hC, v); check(v == 0, "R10", "pointer frozen while active", v, 0);
    rd(4'h4, v); check(v[10] == 1'b1, "R1", "active while running", v, ACT);
    wait_idle(st);
    wr(4'h0, 32'h0);
    throttle = 1'b0;
    check(st == DONE, "R1", "active clears at chain end", st, DONE);
    check(wr_beats == 60 && rd_beats == 8, "R10", "no restart", wr_beats, 60);
    cmp_mem("R10");

    finish_run();
  end
endmodule